// File: doc/BRIEF.md
# Three-Wire Serial Shift Port (Master or Slave)

This block is an 8-bit serial shift port for a three-wire synchronous link made of a shift clock, a data line out and a data line in. A host programs it through a small write interface. The host can load the shift register, read the register back at any time, select master or slave operation, choose whether the data-out pin is driven or left floating, set the clock divider, and start a transfer by raising the busy flag. Master and slave behaviour reach the pins only while the port is enabled.

As master, the block makes the shift clock from the system clock with a programmable half-period. The clock stays low while no transfer is running. As slave, the block takes the clock from an input pin through a two-flop synchronizer and finds its edges in the system clock domain. In both roles the register sends its most significant bit first. The data-out pin changes on falling clock edges, and the data-in pin is sampled on rising edges into the least significant bit. After eight rising edges, busy clears on the next falling edge.

In slave mode the gate on the external clock opens when busy is set. It stays open after busy clears and closes only when the port is disabled or master mode is selected. For this reason, setting busy while the external clock is high shifts in one bit at once. A host load made while the shift clock is high is refused: the register keeps its contents and an error pulse is raised.

Top module: `mw_shift_port`

## Requirements
- R1: After reset, busy, load_err, sck_o, sck_oe, so_oe and rd_data are all 0, and the slave clock gate is closed.
- R2: A write to address 1 sets the control bits: bit 0 enables the port, bit 1 makes the data-out pin driven, and bit 2 selects master. sck_oe equals enable AND master. so_oe equals enable AND driven.
- R3: In master mode with divider value v (address 2), sck_o first rises max(v,1) cycles after the edge that sets busy. It then toggles every max(v,1) cycles and stays low whenever busy is 0.
- R4: A load (address 0) places the data bit 7 on so_o at once. Each falling shift-clock edge moves the current bit 7 of the register to so_o. Each rising edge shifts the register left and takes si_i into bit 0, so after eight pulses the register holds the received byte.
- R5: After eight rising shift-clock edges, busy clears on the next falling edge. In master mode sck_o goes low on that same edge and stays low.
- R6: In slave mode, sck_i is synchronized by two flops. Its edges shift the register only while the slave gate is open. The gate opens when busy is set, and edges before that leave the register unchanged.
- R7: In slave mode the register keeps shifting on sck_i edges after busy has cleared.
- R8: Setting busy in slave mode while the synchronized sck_i is high counts as one rising edge. It shifts one bit in, and seven further pulses then complete the transfer.
- R9: A load written while the shift clock is high (master: sck_o; slave: synchronized sck_i) leaves the register unchanged and raises load_err for one cycle.
- R10: Bit 3 of a control write sets busy only if the same write also sets the enable bit and busy is 0. Disabling the port clears busy.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low reset |
| wr_en | input | 1 | Host write strobe |
| wr_addr | input | 2 | 0 data, 1 control, 2 divider |
| wr_data | input | DATA_W | Host write data |
| rd_data | output | DATA_W | Current shift register |
| busy | output | 1 | Transfer in progress |
| load_err | output | 1 | One-cycle pulse on a refused load |
| sck_o | output | 1 | Master shift clock |
| sck_oe | output | 1 | Shift clock pin drive enable |
| sck_i | input | 1 | External shift clock (slave) |
| so_o | output | 1 | Serial data out |
| so_oe | output | 1 | Data-out pin drive enable |
| si_i | input | 1 | Serial data in |

## Verification
Two functions can fall in the same cycle. In slave mode, arming busy can coincide with a rising edge of the gated clock: the bench holds sck_i high, sets busy, and expects exactly one bit shifted in and a transfer that ends after seven more pulses. A host load can also meet a high shift clock. The bench writes a load with sck_i high and judges it by the unchanged read-back value and a one-cycle load_err pulse. In master transfers, each clock cycle compares sck_o, so_o and busy against a model driven by a cycle counter.

// File: rtl/mw_pkg.sv
package mw_pkg;
    typedef enum logic [1:0] {
        ADR_DATA = 2'd0,
        ADR_CTRL = 2'd1,
        ADR_DIV  = 2'd2,
        ADR_NONE = 2'd3
    } mw_adr_e;

    localparam int CB_EN  = 0;
    localparam int CB_DRV = 1;
    localparam int CB_MST = 2;
    localparam int CB_GO  = 3;
endpackage

// File: rtl/mw_sync.sv
module mw_sync (
    input  logic clk,
    input  logic rst_n,
    input  logic d_i,
    output logic q_o
);
    logic [1:0] s_d, s_q;

    always_comb begin
        s_d = {s_q[0], d_i};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign q_o = s_q[1];
endmodule

// File: rtl/mw_clkgen.sv
module mw_clkgen #(
    parameter int DIV_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run_i,
    input  logic [DIV_W-1:0] half_i,
    output logic             lvl_o,
    output logic             tick_o
);
    typedef struct packed {
        logic [DIV_W-1:0] cnt;
        logic             lvl;
    } gst_t;

    gst_t q, d;
    logic [DIV_W-1:0] half_eff;

    always_comb begin
        half_eff = (half_i == '0) ? DIV_W'(1) : half_i;
        d        = q;
        tick_o   = 1'b0;
        if (!run_i) begin
            d.cnt = '0;
            d.lvl = 1'b0;
        end else if (q.cnt == half_eff - 1'b1) begin
            tick_o = 1'b1;
            d.cnt  = '0;
            d.lvl  = ~q.lvl;
        end else begin
            d.cnt = q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign lvl_o = q.lvl;

    // R3: a level change while running comes only at the end of a half-period
    a_r3_half_period: assert property (@(posedge clk) disable iff (!rst_n)
        (run_i && $past(run_i) && (q.lvl != $past(q.lvl)))
            |-> ($past(q.cnt) == $past(half_eff) - 1'b1));
endmodule

// File: rtl/mw_shift_port.sv
module mw_shift_port
    import mw_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter int DIV_W  = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [1:0]        wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    output logic [DATA_W-1:0] rd_data,
    output logic              busy,
    output logic              load_err,
    output logic              sck_o,
    output logic              sck_oe,
    input  logic              sck_i,
    output logic              so_o,
    output logic              so_oe,
    input  logic              si_i
);
    localparam int CNT_W = $clog2(DATA_W + 1);
    localparam logic [CNT_W-1:0] LAST = CNT_W'(DATA_W);

    typedef struct packed {
        logic              en;
        logic              drv;
        logic              mst;
        logic              busy;
        logic              act;
        logic              g;
        logic              so;
        logic              err;
        logic [CNT_W-1:0]  nbits;
        logic [DATA_W-1:0] sr;
        logic [DIV_W-1:0]  div;
    } st_t;

    st_t  q, d;
    logic sync_lvl, m_lvl, m_tick;
    logic run, g_now, rise, fall, clk_hi, ld_wr, ctl_wr, go;

    mw_sync u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d_i   (sck_i),
        .q_o   (sync_lvl)
    );

    mw_clkgen #(.DIV_W(DIV_W)) u_gen (
        .clk    (clk),
        .rst_n  (rst_n),
        .run_i  (run),
        .half_i (q.div),
        .lvl_o  (m_lvl),
        .tick_o (m_tick)
    );

    always_comb begin
        run    = q.busy & q.mst & q.en;
        g_now  = q.mst ? m_lvl : (q.act & sync_lvl);
        clk_hi = q.mst ? m_lvl : sync_lvl;
        if (q.mst) begin
            rise = run & m_tick & ~m_lvl;
            fall = run & m_tick & m_lvl;
        end else begin
            rise = g_now & ~q.g;
            fall = ~g_now & q.g;
        end
        ld_wr  = wr_en && (wr_addr == ADR_DATA);
        ctl_wr = wr_en && (wr_addr == ADR_CTRL);
        go     = ctl_wr && wr_data[CB_GO] && wr_data[CB_EN] && !q.busy;

        d     = q;
        d.g   = g_now;
        d.err = 1'b0;

        if (rise) begin
            d.sr = {q.sr[DATA_W-2:0], si_i};
            if (q.busy) d.nbits = q.nbits + 1'b1;
        end
        if (fall) begin
            d.so = q.sr[DATA_W-1];
            if (q.busy && q.nbits == LAST) d.busy = 1'b0;
        end
        if (ld_wr) begin
            if (clk_hi) begin
                d.err = 1'b1;
            end else begin
                d.sr = wr_data;
                d.so = wr_data[DATA_W-1];
            end
        end
        if (ctl_wr) begin
            d.en  = wr_data[CB_EN];
            d.drv = wr_data[CB_DRV];
            d.mst = wr_data[CB_MST];
        end
        if (go) begin
            d.busy  = 1'b1;
            d.nbits = '0;
            d.act   = ~wr_data[CB_MST];
        end
        if (wr_en && (wr_addr == ADR_DIV)) d.div = DIV_W'(wr_data);
        if (!d.en) begin
            d.busy = 1'b0;
            d.act  = 1'b0;
        end
        if (d.mst) d.act = 1'b0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign rd_data  = q.sr;
    assign busy     = q.busy;
    assign load_err = q.err;
    assign sck_o    = m_lvl;
    assign sck_oe   = q.en & q.mst;
    assign so_o     = q.so;
    assign so_oe    = q.en & q.drv;

    // R3: master clock idles low without a transfer
    a_r3_idle_low: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> !sck_o);

    // R5: busy ends only after a full byte of rising edges
    a_r5_eight_pulses: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(q.busy) && q.en) |-> ($past(q.nbits) == LAST));

    // R4: a rising edge moves the register left and takes si_i into bit 0
    a_r4_shift_in: assert property (@(posedge clk) disable iff (!rst_n)
        (rise && !ld_wr) |=> (rd_data == {$past(q.sr[DATA_W-2:0]), $past(si_i)}));

    // R10: a control write without enable never leaves busy set
    a_r10_go_disabled: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_wr && !wr_data[CB_EN]) |=> !busy);

    // R9: a load against a high clock raises the error pulse
    a_r9_refused_load: assert property (@(posedge clk) disable iff (!rst_n)
        (ld_wr && clk_hi) |=> load_err);
endmodule

// File: tb/sim_mw_shift_port.sv
`timescale 1ns/1ps
module sim_mw_shift_port;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_en = 1'b0;
    logic [1:0] wr_addr = 2'd0;
    logic [7:0] wr_data = 8'd0;
    logic [7:0] rd_data;
    logic       busy, load_err, sck_o, sck_oe, so_o, so_oe;
    logic       sck_i = 1'b0;
    logic       si_i = 1'b0;
    int n_chk = 0;
    int n_fail = 0;
    bit done = 0;

    always #2 clk = ~clk;

    mw_shift_port u0 (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .rd_data(rd_data), .busy(busy), .load_err(load_err), .sck_o(sck_o),
        .sck_oe(sck_oe), .sck_i(sck_i), .so_o(so_o), .so_oe(so_oe), .si_i(si_i)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] a, input logic [7:0] dt);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = dt;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    // reference: cycle counter since the edge that armed busy
    task automatic master_xfer(input logic [7:0] tx, input logic [7:0] rx, input int dv);
        int h;
        h = (dv == 0) ? 1 : dv;
        wr(2'd1, 8'h07);
        wr(2'd2, dv[7:0]);
        wr(2'd0, tx);
        chk("R4 so after load", so_o, tx[7]);
        si_i = rx[7];
        wr(2'd1, 8'h0F);
        for (int n = 0; n <= 16 * h + 2; n++) begin
            int f, k;
            f = n / (2 * h);
            chk("R5 busy per cycle", busy, (n < 16 * h));
            chk("R3 sck per cycle", sck_o, (n < 16 * h) && (((n / h) % 2) == 1));
            chk("R4 so per cycle", so_o, (f < 8) ? tx[7 - f] : rx[7]);
            k = (n + 1) / (2 * h);
            if (k > 7) k = 7;
            si_i = rx[7 - k];
            @(negedge clk);
        end
        chk("R4 received byte", rd_data, rx);
    endtask

    task automatic pulses(input int cnt, input logic [7:0] pat);
        for (int i = 0; i < cnt; i++) begin
            si_i = pat[7 - i];
            repeat (4) @(negedge clk);
            sck_i = 1'b1;
            repeat (4) @(negedge clk);
            sck_i = 1'b0;
        end
        repeat (4) @(negedge clk);
    endtask

    initial begin
        #(4 * 200000);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 busy", busy, 0);
        chk("R1 rd_data", rd_data, 0);
        chk("R1 sck_o", sck_o, 0);
        chk("R1 oe", {sck_oe, so_oe}, 0);
        chk("R1 load_err", load_err, 0);

        wr(2'd1, 8'h07); chk("R2 en drv mst", {sck_oe, so_oe}, 2'b11);
        wr(2'd1, 8'h05); chk("R2 en mst", {sck_oe, so_oe}, 2'b10);
        wr(2'd1, 8'h03); chk("R2 en drv", {sck_oe, so_oe}, 2'b01);
        wr(2'd1, 8'h06); chk("R2 disabled", {sck_oe, so_oe}, 2'b00);

        wr(2'd1, 8'h0C); chk("R10 go while disabled", busy, 0);

        master_xfer(8'hA5, 8'h3C, 1);
        master_xfer(8'h5A, 8'hC3, 3);
        master_xfer(8'h81, 8'h7E, 0);

        // slave: gate closed before busy
        wr(2'd1, 8'h03);
        wr(2'd0, 8'h96);
        pulses(8, 8'hFF);
        chk("R6 no shift before busy", rd_data, 8'h96);
        wr(2'd1, 8'h0B);
        chk("R6 busy armed", busy, 1);
        pulses(8, 8'h4D);
        chk("R6 slave byte", rd_data, 8'h4D);
        chk("R5 slave busy clear", busy, 0);
        pulses(3, 8'hE0);
        chk("R7 shifts after busy", rd_data, 8'h6F);
        chk("R7 busy stays low", busy, 0);

        // close gate, then hazards with clock high
        wr(2'd1, 8'h00);
        wr(2'd1, 8'h03);
        wr(2'd0, 8'h3C);
        chk("R9 load while low", rd_data, 8'h3C);
        si_i = 1'b1;
        sck_i = 1'b1;
        repeat (4) @(negedge clk);
        chk("R6 standby ignores clock", rd_data, 8'h3C);
        wr(2'd0, 8'hAA);
        chk("R9 load_err pulse", load_err, 1);
        chk("R9 register kept", rd_data, 8'h3C);
        @(negedge clk);
        chk("R9 pulse one cycle", load_err, 0);
        si_i = 1'b0;
        wr(2'd1, 8'h0B);
        repeat (4) @(negedge clk);
        chk("R8 one bit on arm", rd_data, 8'h78);
        chk("R8 busy set", busy, 1);
        sck_i = 1'b0;
        repeat (4) @(negedge clk);
        chk("R8 still busy", busy, 1);
        pulses(7, 8'hFE);
        chk("R8 byte after seven", rd_data, 8'h7F);
        chk("R8 busy clear", busy, 0);

        wr(2'd1, 8'h00);
        chk("R10 disable", busy, 0);

        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule